// File: doc/BRIEF.md
# Indexed-Access Real-Time Clock Core

This block is a real-time clock reached through a two-port byte bus. A write to the index port latches a register number. A later read or write on the data port then acts on that latched register. The registers hold a calendar with seconds, minutes, hours, day of week, day of month, month and year, plus three alarm bytes. There are also four control bytes and a window of general-purpose battery-backed RAM.

The calendar advances by one second on each cycle in which the one-second strobe is high. One control bit freezes the calendar so that software can load a new time without it rolling underneath. Two other control bits select the encoding and the hour format:

- Encoding is either plain binary or packed BCD.
- Hours are either 12-hour with a PM flag or 24-hour.

All of these modes share one set of time bytes. The counter decodes the stored bytes, increments them, and writes them back in the encoding that is currently selected.

Top module: `rtc_idx_core`

## Requirements
- R1: A data-port write or read acts on the register whose number was last written to the index port (`bus_port`=0 selects the index port, `bus_port`=1 the data port). `bus_rdata` shows the selected register in the cycle after the index write, and shows a written value in the cycle after the data write.
- R2: After reset the registers hold the following values:
  - Control byte B at index 0x0B reads 0x02 (BCD, 24-hour, running).
  - Seconds (0x00) reads 0.
  - Day of week (0x06), day of month (0x07) and month (0x08) each read 1.
- R3: While bit 7 of control byte B is 1, the calendar does not advance on a strobe. After the bit is cleared, strobes that arrived while it was set are not replayed, and counting resumes at the next strobe.
- R4: Bit 2 of control byte B selects the encoding: 1 means binary, 0 means packed BCD. Seconds and minutes count 0 to 59 in the selected encoding and carry into the next field. For example, BCD minutes 0x09 with seconds 0x59 become minutes 0x10 with seconds 0x00.
- R5: Bit 1 of control byte B selects 24-hour format when 1. In 12-hour format, hours bit 7 is the PM flag and the hour (1 to 12) sits in the low bits. The hour counts 11, 12, 1, and the PM flag toggles on the step from 11 to 12.
- R6: In 24-hour format, hour 23 rolls to 0 and advances the day. Day of week counts 1 to 7 and wraps to 1.
- R7: Day of month rolls to 1 after the last day of the month and advances the month. The last day is 30 in months 4, 6, 9 and 11, and 31 in the other months except February. February ends at 29 when the year value is divisible by 4 and at 28 otherwise. Month 12 rolls to 1 and advances the year, and year 99 wraps to 0.
- R8: Indices 0x0E to 0x7F address 114 bytes of general-purpose RAM, each byte readable and writable.
- R9: Control byte D (0x0D) reads `vbat_ok` in bit 7 and 0 in bits 6:0. Control byte C (0x0C) reads 0x00. Writes to either byte are ignored.
- R10: A read at an index above 0x7F returns 0x00, and a data write at such an index changes no register or RAM byte.
- R11: The alarm bytes (0x01, 0x03, 0x05) and control byte A (0x0A) return the last value written to them, and strobes leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for the selected port |
| bus_port | input | 1 | Port select: 0 index port, 1 data port |
| bus_wdata | input | 8 | Write data for the index or data port |
| bus_rdata | output | 8 | Data-port read value for the latched index |
| sec_tick | input | 1 | One-second advance strobe, one cycle wide |
| vbat_ok | input | 1 | Backup-supply-valid status, reported in control byte D |

## Verification
Every register write and every counting step lands on the rising edge where the strobe or write is high. The read path is combinational, so the bench expects each result exactly one edge after its stimulus. Every stimulus is driven at a falling edge, held across one rising edge, and released at the next falling edge. `bus_rdata` is sampled at that same falling edge, so each check sees the state after exactly one update and never a mid-edge value.

The calendar carry cases are set up just below each rollover and then advanced with a single strobe. This isolates the carry into minutes, hours, day, month and year from the carries before it.

// File: rtl/rtc_idx_pkg.sv
// Shared constants and encoding helpers for the indexed real-time clock.
// Assumes byte-wide registers and calendar values that fit in 0..99.
package rtc_idx_pkg;

    // Time register slots (slot number equals bus index)
    localparam int T_SEC   = 0;
    localparam int T_HOUR  = 4;
    localparam int T_DOW   = 6;
    localparam int T_DOM   = 7;
    localparam int T_MON   = 8;
    localparam int T_YEAR  = 9;
    localparam int T_MIN   = 2;
    localparam int TIME_REGS = 10;

    // Control byte B bit positions
    localparam int CB_FREEZE = 7;
    localparam int CB_BIN    = 2;
    localparam int CB_H24    = 1;

    // Decode a stored byte to a binary value under the selected encoding.
    function automatic logic [7:0] val_dec(input logic [7:0] raw, input logic bin);
        if (bin) return raw;
        return ({4'd0, raw[7:4]} * 8'd10) + {4'd0, raw[3:0]};
    endfunction

    // Encode a binary value (0..99) into the selected encoding.
    function automatic logic [7:0] val_enc(input logic [7:0] v, input logic bin);
        logic [7:0] tens;
        logic [7:0] ones;
        tens = v / 8'd10;
        ones = v % 8'd10;
        if (bin) return v;
        return {tens[3:0], ones[3:0]};
    endfunction

    // Last day of a month; a year divisible by 4 has a 29-day February.
    function automatic logic [7:0] month_len(input logic [7:0] mo, input logic [7:0] yr);
        case (mo)
            8'd2:                       return (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:    return 8'd30;
            default:                    return 8'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_idx_nvram.sv
// General-purpose byte RAM behind the data port.
// Assumes addr is already range-checked by the caller; contents are not
// reset, since the storage models battery-backed memory.
module rtc_idx_nvram #(
    parameter int DW    = 8,
    parameter int DEPTH = 114,
    parameter int AW    = 7
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    // Byte write on the data port
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    // Combinational read of the addressed byte
    assign rdata = mem[addr];

endmodule

// File: rtl/rtc_idx_calendar.sv
// Time and alarm register file with the one-second counting chain.
// Stored bytes are decoded under the current encoding and hour format,
// advanced, and re-encoded in the same modes. A bus write to a slot wins
// over a strobe in the same cycle. Assumes sec_tick is one cycle wide.
module rtc_idx_calendar
    import rtc_idx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic       freeze,
    input  logic       bin_mode,
    input  logic       h24,
    input  logic       wr_en,
    input  logic [3:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] slot_q [TIME_REGS]
);

    logic [7:0] nxt [TIME_REGS];
    logic [7:0] sec_v, min_v, dow_v, dom_v, mon_v, yr_v;
    logic [7:0] h12_v, hr24_v, nhr, nh12, dim;
    logic [7:0] h12_enc;
    logic       c_min, c_hr, c_day, c_mon, c_yr, adv;
    logic [TIME_REGS*8-1:0] flat;

    assign adv = sec_tick && !freeze;

    // Decode current fields and build the carry chain
    always_comb begin
        sec_v  = val_dec(slot_q[T_SEC], bin_mode);
        min_v  = val_dec(slot_q[T_MIN], bin_mode);
        dow_v  = val_dec(slot_q[T_DOW], bin_mode);
        dom_v  = val_dec(slot_q[T_DOM], bin_mode);
        mon_v  = val_dec(slot_q[T_MON], bin_mode);
        yr_v   = val_dec(slot_q[T_YEAR], bin_mode);
        h12_v  = val_dec(slot_q[T_HOUR] & 8'h3F, bin_mode);
        if (h24) hr24_v = val_dec(slot_q[T_HOUR], bin_mode);
        else     hr24_v = ((h12_v == 8'd12) ? 8'd0 : h12_v) +
                          (slot_q[T_HOUR][7] ? 8'd12 : 8'd0);
        dim    = month_len(mon_v, yr_v);
        c_min  = sec_v >= 8'd59;
        c_hr   = c_min && (min_v >= 8'd59);
        c_day  = c_hr && (hr24_v >= 8'd23);
        c_mon  = c_day && (dom_v >= dim);
        c_yr   = c_mon && (mon_v >= 8'd12);
    end

    // Compute the next value of every slot for one strobe
    always_comb begin
        for (int i = 0; i < TIME_REGS; i++) nxt[i] = slot_q[i];
        nhr  = c_day ? 8'd0 : hr24_v + 8'd1;
        nh12 = (nhr == 8'd0) ? 8'd12 : ((nhr > 8'd12) ? nhr - 8'd12 : nhr);
        h12_enc = val_enc(nh12, bin_mode);
        nxt[T_SEC] = c_min ? 8'h00 : val_enc(sec_v + 8'd1, bin_mode);
        if (c_min) nxt[T_MIN] = c_hr ? 8'h00 : val_enc(min_v + 8'd1, bin_mode);
        if (c_hr) begin
            if (h24) nxt[T_HOUR] = val_enc(nhr, bin_mode);
            else     nxt[T_HOUR] = {(nhr >= 8'd12), h12_enc[6:0]};
        end
        if (c_day) begin
            nxt[T_DOW] = (dow_v >= 8'd7) ? 8'h01 : val_enc(dow_v + 8'd1, bin_mode);
            nxt[T_DOM] = c_mon ? 8'h01 : val_enc(dom_v + 8'd1, bin_mode);
        end
        if (c_mon) nxt[T_MON] = c_yr ? 8'h01 : val_enc(mon_v + 8'd1, bin_mode);
        if (c_yr)  nxt[T_YEAR] = (yr_v >= 8'd99) ? 8'h00 : val_enc(yr_v + 8'd1, bin_mode);
    end

    // One storage byte per slot: reset, bus write, or strobe advance
    for (genvar g = 0; g < TIME_REGS; g++) begin : g_slot
        localparam logic [7:0] RST_VAL =
            (g == T_DOW || g == T_DOM || g == T_MON) ? 8'h01 : 8'h00;
        always_ff @(posedge clk) begin
            if (!rst_n)                           slot_q[g] <= RST_VAL;
            else if (wr_en && wr_sel == 4'(g))    slot_q[g] <= wr_data;
            else if (adv)                         slot_q[g] <= nxt[g];
        end
        assign flat[g*8 +: 8] = slot_q[g];
    end

    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !wr_en) |=> $stable(flat)); // R3
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_tick && !wr_en) |=> $stable(flat)); // R11
    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_en && sec_v == 8'd59) |=> (slot_q[T_SEC] == 8'h00)); // R4
    AST_DOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_en && c_day && dow_v == 8'd7) |=> (slot_q[T_DOW] == 8'h01)); // R6
    AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_en && c_yr && yr_v == 8'd99) |=> (slot_q[T_YEAR] == 8'h00)); // R7

endmodule

// File: rtl/rtc_idx_core.sv
// Indexed real-time clock top: index latch, control bytes, read mux and
// write decode onto the calendar slots and the general-purpose RAM.
// Assumes one bus access per cycle; reads have no side effects.
module rtc_idx_core
    import rtc_idx_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int RAM_FIRST = 14,
    parameter int RAM_LAST  = 127
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_port,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sec_tick,
    input  logic              vbat_ok
);

    localparam int RAM_DEPTH = RAM_LAST - RAM_FIRST + 1;
    localparam int RAM_AW    = $clog2(RAM_DEPTH);
    localparam logic [DATA_W-1:0] RAM_LO  = DATA_W'(RAM_FIRST);
    localparam logic [DATA_W-1:0] RAM_HI  = DATA_W'(RAM_LAST);
    localparam logic [DATA_W-1:0] TIME_HI = DATA_W'(TIME_REGS - 1);
    localparam logic [DATA_W-1:0] IX_A    = DATA_W'(10);
    localparam logic [DATA_W-1:0] IX_B    = DATA_W'(11);
    localparam logic [DATA_W-1:0] IX_C    = DATA_W'(12);
    localparam logic [DATA_W-1:0] IX_D    = DATA_W'(13);

    logic [DATA_W-1:0] idx_q, ctl_a_q, ctl_b_q, ram_rd;
    logic [7:0]        slot_q [TIME_REGS];
    logic              data_wr, in_time, in_ram;
    logic [RAM_AW-1:0] ram_addr;

    assign data_wr  = bus_we && bus_port;
    assign in_time  = idx_q <= TIME_HI;
    assign in_ram   = (idx_q >= RAM_LO) && (idx_q <= RAM_HI);
    assign ram_addr = RAM_AW'(idx_q - RAM_LO);

    // Index latch written through the index port
    always_ff @(posedge clk) begin
        if (!rst_n)                   idx_q <= '0;
        else if (bus_we && !bus_port) idx_q <= bus_wdata;
    end

    // Control bytes A and B; C and D are not storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_a_q <= '0;
            ctl_b_q <= DATA_W'(8'h02);
        end else if (data_wr && idx_q == IX_A) begin
            ctl_a_q <= bus_wdata;
        end else if (data_wr && idx_q == IX_B) begin
            ctl_b_q <= bus_wdata;
        end
    end

    rtc_idx_calendar u_cal (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_tick (sec_tick),
        .freeze   (ctl_b_q[CB_FREEZE]),
        .bin_mode (ctl_b_q[CB_BIN]),
        .h24      (ctl_b_q[CB_H24]),
        .wr_en    (data_wr && in_time),
        .wr_sel   (idx_q[3:0]),
        .wr_data  (bus_wdata[7:0]),
        .slot_q   (slot_q)
    );

    rtc_idx_nvram #(.DW(DATA_W), .DEPTH(RAM_DEPTH), .AW(RAM_AW)) u_ram (
        .clk   (clk),
        .we    (data_wr && in_ram),
        .addr  (ram_addr),
        .wdata (bus_wdata),
        .rdata (ram_rd)
    );

    // Data-port read mux for the latched index
    always_comb begin
        bus_rdata = '0;
        if (in_time)             bus_rdata = DATA_W'(slot_q[idx_q[3:0]]);
        else if (idx_q == IX_A)  bus_rdata = ctl_a_q;
        else if (idx_q == IX_B)  bus_rdata = ctl_b_q;
        else if (idx_q == IX_C)  bus_rdata = '0;
        else if (idx_q == IX_D)  bus_rdata = {vbat_ok, {(DATA_W-1){1'b0}}};
        else if (in_ram)         bus_rdata = ram_rd;
    end

    AST_RAM_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && in_ram) |=> (bus_rdata == $past(bus_wdata))); // R8
    AST_HIGH_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q > RAM_HI) |-> (bus_rdata == '0)); // R10

endmodule

// File: tb/rtc_idx_core_tb_top.sv
// Directed bench for rtc_idx_core: one task per scenario, each checking itself.
module rtc_idx_core_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic       bus_port = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       sec_tick = 1'b0;
    logic       vbat_ok = 1'b1;
    int         n_vec = 0;
    int         n_err = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    rtc_idx_core dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_port(bus_port),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sec_tick(sec_tick), .vbat_ok(vbat_ok)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic port, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_port = port; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic put(input logic [7:0] ix, input logic [7:0] d);
        bus_wr(1'b0, ix);
        bus_wr(1'b1, d);
    endtask

    task automatic get(input logic [7:0] ix, output logic [7:0] d);
        bus_wr(1'b0, ix);
        d = bus_rdata;
    endtask

    task automatic tick_once();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic set_date(input logic [7:0] yr, mo, dm, hr);
        put(8'h09, yr); put(8'h08, mo); put(8'h07, dm);
        put(8'h04, hr); put(8'h02, 8'h59); put(8'h00, 8'h59);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        get(8'h0B, v); chk("R2 ctl B reset", v, 8'h02);
        get(8'h00, v); chk("R2 sec reset", v, 8'h00);
        get(8'h06, v); chk("R2 dow reset", v, 8'h01);
        get(8'h07, v); chk("R2 dom reset", v, 8'h01);
        get(8'h08, v); chk("R2 month reset", v, 8'h01);
    endtask

    task automatic t_index();
        logic [7:0] v;
        put(8'h02, 8'h33);
        bus_wr(1'b0, 8'h00); bus_wr(1'b1, 8'h21);
        chk("R1 data write visible next cycle", bus_rdata, 8'h21);
        get(8'h02, v); chk("R1 other index untouched", v, 8'h33);
    endtask

    task automatic t_bcd_bin();
        logic [7:0] v;
        put(8'h0B, 8'h02);
        put(8'h02, 8'h09); put(8'h00, 8'h59);
        tick_once();
        get(8'h00, v); chk("R4 bcd sec wrap", v, 8'h00);
        get(8'h02, v); chk("R4 bcd min carry", v, 8'h10);
        put(8'h0B, 8'h06);
        put(8'h04, 8'd5); put(8'h02, 8'd59); put(8'h00, 8'd59);
        tick_once();
        get(8'h02, v); chk("R4 bin min wrap", v, 8'd0);
        get(8'h04, v); chk("R4 bin hour carry", v, 8'd6);
        put(8'h00, 8'd9);
        tick_once();
        get(8'h00, v); chk("R4 bin sec 9->10", v, 8'd10);
    endtask

    task automatic t_freeze();
        logic [7:0] v;
        put(8'h0B, 8'h82);
        put(8'h00, 8'h10);
        tick_once(); tick_once();
        get(8'h00, v); chk("R3 frozen sec", v, 8'h10);
        put(8'h0B, 8'h02);
        get(8'h00, v); chk("R3 no replay on release", v, 8'h10);
        tick_once();
        get(8'h00, v); chk("R3 resumes at next tick", v, 8'h11);
    endtask

    task automatic t_12h();
        logic [7:0] v;
        put(8'h0B, 8'h00);
        put(8'h04, 8'h11); put(8'h02, 8'h59); put(8'h00, 8'h59);
        tick_once();
        get(8'h04, v); chk("R5 11AM->12PM", v, 8'h92);
        put(8'h02, 8'h59); put(8'h00, 8'h59);
        tick_once();
        get(8'h04, v); chk("R5 12PM->1PM", v, 8'h81);
        put(8'h06, 8'h03);
        put(8'h04, 8'h91); put(8'h02, 8'h59); put(8'h00, 8'h59);
        tick_once();
        get(8'h04, v); chk("R5 11PM->12AM", v, 8'h12);
        get(8'h06, v); chk("R5 day advance at midnight", v, 8'h04);
    endtask

    task automatic t_day();
        logic [7:0] v;
        put(8'h0B, 8'h02);
        put(8'h06, 8'h07);
        set_date(8'h20, 8'h03, 8'h15, 8'h23);
        tick_once();
        get(8'h04, v); chk("R6 hour 23->0", v, 8'h00);
        get(8'h06, v); chk("R6 dow 7->1", v, 8'h01);
        get(8'h07, v); chk("R6 dom advance", v, 8'h16);
    endtask

    task automatic t_month();
        logic [7:0] v;
        set_date(8'h24, 8'h02, 8'h28, 8'h23); tick_once();
        get(8'h07, v); chk("R7 leap feb 28->29", v, 8'h29);
        set_date(8'h24, 8'h02, 8'h29, 8'h23); tick_once();
        get(8'h07, v); chk("R7 leap feb end dom", v, 8'h01);
        get(8'h08, v); chk("R7 leap feb end month", v, 8'h03);
        set_date(8'h23, 8'h02, 8'h28, 8'h23); tick_once();
        get(8'h08, v); chk("R7 common feb end month", v, 8'h03);
        set_date(8'h23, 8'h04, 8'h30, 8'h23); tick_once();
        get(8'h07, v); chk("R7 april end dom", v, 8'h01);
        set_date(8'h23, 8'h05, 8'h30, 8'h23); tick_once();
        get(8'h07, v); chk("R7 may 30->31", v, 8'h31);
        set_date(8'h99, 8'h12, 8'h31, 8'h23); tick_once();
        get(8'h08, v); chk("R7 dec->jan", v, 8'h01);
        get(8'h09, v); chk("R7 year 99->0", v, 8'h00);
    endtask

    task automatic t_ram();
        logic [7:0] v;
        put(8'h0E, 8'hA5); put(8'h7F, 8'h3C); put(8'h40, 8'h5A);
        get(8'h0E, v); chk("R8 ram first byte", v, 8'hA5);
        get(8'h7F, v); chk("R8 ram last byte", v, 8'h3C);
        get(8'h40, v); chk("R8 ram middle byte", v, 8'h5A);
    endtask

    task automatic t_ctl_cd();
        logic [7:0] v;
        vbat_ok = 1'b1;
        get(8'h0D, v); chk("R9 D valid", v, 8'h80);
        vbat_ok = 1'b0;
        put(8'h0D, 8'hFF);
        get(8'h0D, v); chk("R9 D read-only", v, 8'h00);
        put(8'h0C, 8'hFF);
        get(8'h0C, v); chk("R9 C reads zero", v, 8'h00);
        vbat_ok = 1'b1;
    endtask

    task automatic t_high_idx();
        logic [7:0] v;
        put(8'h00, 8'h44);
        put(8'h80, 8'h77);
        chk("R10 read above window", bus_rdata, 8'h00);
        put(8'hFF, 8'h66);
        chk("R10 read at 0xFF", bus_rdata, 8'h00);
        get(8'h7F, v); chk("R10 ram last kept", v, 8'h3C);
        get(8'h0E, v); chk("R10 ram first kept", v, 8'hA5);
        get(8'h00, v); chk("R10 sec alias kept", v, 8'h44);
    endtask

    task automatic t_alarm();
        logic [7:0] v;
        put(8'h01, 8'h30); put(8'h03, 8'h45); put(8'h05, 8'h12); put(8'h0A, 8'h26);
        tick_once(); tick_once();
        get(8'h01, v); chk("R11 sec alarm", v, 8'h30);
        get(8'h03, v); chk("R11 min alarm", v, 8'h45);
        get(8'h05, v); chk("R11 hour alarm", v, 8'h12);
        get(8'h0A, v); chk("R11 ctl A", v, 8'h26);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog all requirements actual=timeout expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_index();
        t_bcd_bin();
        t_freeze();
        t_12h();
        t_day();
        t_month();
        t_ram();
        t_ctl_cd();
        t_high_idx();
        t_alarm();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

endmodule